// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Control

This block turns parallel characters into an asynchronous serial stream. A host places a character into a one-deep holding slot through a simple write strobe. When the line is free, the character moves into a shift register and leaves on the serial output. Each frame has a low start bit, 5 to 8 data bits sent least-significant first, an optional parity bit and one or two high stop bits. Timing comes from an enable pulse at sixteen times the bit rate. A separate baud generator supplies that pulse.

Single-cycle command strobes control the line. They enable or disable the transmitter, reset it at once, and start or end a forced-low break. A clear-to-send input can hold back new characters. The request-to-send output is set by command. Optionally it drops by itself one bit time after the last character of a message has left, once the transmitter has been disabled. Two status outputs report whether the holding slot can take a character and whether everything has drained.

Top module: `uart_tx_hs`

## Requirements
- R1: A frame is one low start bit, then the data bits least-significant first, then the parity bit if enabled, then the stop bits (high). The data-bit count is 5 + `cfgDataBits` (code 0..3 gives 5..8 bits). `cfgTwoStop`=1 selects two stop bits and 0 selects one.
- R2: `cfgParity` code 1 selects even parity, code 2 selects odd parity, and codes 0 and 3 send no parity bit. Parity covers the configured data bits only. With even parity the total number of ones, parity bit included, is even. With odd parity it is odd.
- R3: Every bit lasts 16 `tick16` pulses. `txd` changes only in the cycle after a tick or after a reset or break command.
- R4: `txRdy` is high while the holding slot is empty. An accepted write drops it until the character moves to the shift register. A write while `txRdy` is low is discarded.
- R5: When no frame is in flight, nothing is held and no break is active, `txEmp` is high and `txd` is high (mark). `txEmp` falls when a character is written.
- R6: A disable command lets the frame in flight finish completely.
- R7: A reset command stops the frame at once. `txd` returns to mark, the holding slot empties and the transmitter is disabled.
- R8: After reset or disable, nothing is sent until an enable command arrives.
- R9: With `cfgCtsCheck`=1, a frame starts only while `ctsIn` is high. A frame already started completes even if `ctsIn` falls, and the line then holds mark.
- R10: A break-start command drives `txd` low continuously from the next cycle, whatever the state of `ctsIn`, and drops any frame in flight.
- R11: After a break-stop command, `txd` is high for at least one bit time (64 clocks at a tick every 4 clocks) before a new start bit.
- R12: An assert command raises `rtsOut`. With `cfgAutoRts`=1, when a frame ends while the transmitter is disabled, `rtsOut` falls 16 ticks after the end of the last stop bit. It stays low until the next assert command.
- R13: A character written while the transmitter is disabled is kept and is sent after the next enable command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| cfgDataBits | input | 2 | Data bits minus 5 |
| cfgParity | input | 2 | 0/3 none, 1 even, 2 odd |
| cfgTwoStop | input | 1 | Two stop bits when set |
| cfgCtsCheck | input | 1 | Gate frame starts on ctsIn |
| cfgAutoRts | input | 1 | Drop rtsOut after the final frame when disabled |
| cmdEnable | input | 1 | Enable strobe |
| cmdDisable | input | 1 | Disable strobe (wins over enable) |
| cmdReset | input | 1 | Immediate transmitter reset strobe |
| cmdBreakStart | input | 1 | Begin forced-low line |
| cmdBreakStop | input | 1 | End forced-low line |
| cmdRtsAssert | input | 1 | Raise rtsOut |
| wrValid | input | 1 | Host write strobe |
| wrData | input | 8 | Character to send |
| ctsIn | input | 1 | Clear-to-send, high means asserted |
| txd | output | 1 | Serial output, registered |
| rtsOut | output | 1 | Request-to-send, high means asserted |
| txRdy | output | 1 | Holding slot can accept a character |
| txEmp | output | 1 | Nothing held or sending, line at mark |

## Verification
The properties assume that `tick16` is a single-cycle pulse and that command strobes last one cycle. They also assume the configuration inputs do not change while a frame is in flight. The bench raises `tick16` for one cycle in every four. It pulses each command for exactly one clock, driven on the falling edge. It changes configuration only after `txEmp` has returned high. A serial monitor decodes each frame with the configuration in force and compares it against a queue filled by the write task. Runs that deliberately cut frames short (reset, break) pause the monitor and leave the queue untouched.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int OVERSAMPLE = 16;
  localparam int DATA_MAX   = 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } parity_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic finish;
    logic flush;
    logic brkSet;
    logic brkClr;
  } tx_strobe_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = uart_tx_pkg::OVERSAMPLE
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       cmdEnable,
  input  logic       cmdDisable,
  input  logic       cmdReset,
  input  logic       cmdBreakStart,
  input  logic       cmdBreakStop,
  input  logic       cmdRtsAssert,
  input  logic       cfgCtsCheck,
  input  logic       cfgAutoRts,
  input  logic       ctsIn,
  input  logic       holdValid,
  input  logic       lastBit,
  output tx_strobe_t strobe,
  output logic       rtsOut,
  output logic       txEmp
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic enabled, busy, breakOn, brkRecover, rtsWait;
  logic [SUB_W-1:0] subCnt;
  logic tickLive, bitEnd, waitEnd, canLoad;

  always_comb begin
    tickLive = tick16 && !breakOn && !cmdReset && !cmdBreakStart;
    bitEnd   = tickLive && busy && (subCnt == SUB_LAST);
    waitEnd  = tickLive && !busy && (brkRecover || rtsWait) && (subCnt == SUB_LAST);
    canLoad  = tickLive && !busy && !brkRecover && !rtsWait && enabled &&
               holdValid && (!cfgCtsCheck || ctsIn);
    strobe        = '0;
    strobe.flush  = cmdReset;
    strobe.brkSet = cmdBreakStart && !cmdReset;
    strobe.brkClr = cmdBreakStop && breakOn && !cmdReset && !cmdBreakStart;
    strobe.load   = canLoad;
    strobe.shift  = bitEnd && !lastBit;
    strobe.finish = bitEnd && lastBit;
    txEmp = !busy && !holdValid && !breakOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled    <= 1'b0;
      busy       <= 1'b0;
      breakOn    <= 1'b0;
      brkRecover <= 1'b0;
      rtsWait    <= 1'b0;
      subCnt     <= '0;
    end else if (cmdReset) begin
      enabled    <= 1'b0;
      busy       <= 1'b0;
      breakOn    <= 1'b0;
      brkRecover <= 1'b0;
      rtsWait    <= 1'b0;
      subCnt     <= '0;
    end else begin
      if (cmdDisable)     enabled <= 1'b0;
      else if (cmdEnable) enabled <= 1'b1;

      if (strobe.brkSet) begin
        breakOn    <= 1'b1;
        busy       <= 1'b0;
        brkRecover <= 1'b0;
        rtsWait    <= 1'b0;
        subCnt     <= '0;
      end else if (strobe.brkClr) begin
        breakOn    <= 1'b0;
        brkRecover <= 1'b1;
        subCnt     <= '0;
      end else if (tickLive) begin
        if (canLoad) begin
          busy   <= 1'b1;
          subCnt <= '0;
        end else if (busy || brkRecover || rtsWait) begin
          if (subCnt == SUB_LAST) begin
            subCnt <= '0;
            if (busy) begin
              if (lastBit) begin
                busy <= 1'b0;
                if (cfgAutoRts && !enabled) rtsWait <= 1'b1;
              end
            end else begin
              brkRecover <= 1'b0;
              rtsWait    <= 1'b0;
            end
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   rtsOut <= 1'b0;
    else if (cmdRtsAssert)       rtsOut <= 1'b1;
    else if (waitEnd && rtsWait) rtsOut <= 1'b0;
  end
endmodule

// File: rtl/uart_tx_dpath.sv
module uart_tx_dpath
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX = uart_tx_pkg::DATA_MAX
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrValid,
  input  logic [DATA_MAX-1:0] wrData,
  input  logic [1:0]          cfgDataBits,
  input  logic [1:0]          cfgParity,
  input  logic                cfgTwoStop,
  input  tx_strobe_t          strobe,
  output logic                txd,
  output logic                txRdy,
  output logic                holdValid,
  output logic                lastBit
);
  localparam int FRAME_MAX = DATA_MAX + 3;
  localparam int LEFT_W    = $clog2(FRAME_MAX + 1);

  logic [DATA_MAX-1:0]  holdData;
  logic [FRAME_MAX-1:0] shreg, frameImg;
  logic [LEFT_W-1:0]    bitsLeft, frameLen, nBits;
  logic                 parOn, parBit, txdReg;

  always_comb begin
    nBits    = LEFT_W'(cfgDataBits) + LEFT_W'(5);
    parOn    = (cfgParity == PAR_EVEN) || (cfgParity == PAR_ODD);
    parBit   = 1'b0;
    frameImg = '1;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(nBits)) begin
        frameImg[i] = holdData[i];
        parBit      = parBit ^ holdData[i];
      end
    end
    if (cfgParity == PAR_ODD) parBit = ~parBit;
    if (parOn) frameImg[nBits] = parBit;
    frameLen = nBits + LEFT_W'(parOn) + (cfgTwoStop ? LEFT_W'(2) : LEFT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      shreg     <= '1;
      bitsLeft  <= '0;
      txdReg    <= 1'b1;
    end else if (strobe.flush) begin
      holdValid <= 1'b0;
      shreg     <= '1;
      bitsLeft  <= '0;
      txdReg    <= 1'b1;
    end else begin
      if (strobe.load) begin
        shreg     <= frameImg;
        bitsLeft  <= frameLen;
        txdReg    <= 1'b0;
        holdValid <= 1'b0;
      end else if (strobe.shift) begin
        txdReg   <= shreg[0];
        shreg    <= {1'b1, shreg[FRAME_MAX-1:1]};
        bitsLeft <= bitsLeft - 1'b1;
      end else if (strobe.finish || strobe.brkClr) begin
        txdReg <= 1'b1;
      end
      if (strobe.brkSet) begin
        txdReg   <= 1'b0;
        bitsLeft <= '0;
      end
      if (wrValid && !holdValid) begin
        holdData  <= wrData;
        holdValid <= 1'b1;
      end
    end
  end

  assign txd     = txdReg;
  assign txRdy   = !holdValid;
  assign lastBit = (bitsLeft == '0);
endmodule

// File: rtl/uart_tx_hs.sv
module uart_tx_hs
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = uart_tx_pkg::OVERSAMPLE,
  parameter int DATA_MAX   = uart_tx_pkg::DATA_MAX
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick16,
  input  logic [1:0]          cfgDataBits,
  input  logic [1:0]          cfgParity,
  input  logic                cfgTwoStop,
  input  logic                cfgCtsCheck,
  input  logic                cfgAutoRts,
  input  logic                cmdEnable,
  input  logic                cmdDisable,
  input  logic                cmdReset,
  input  logic                cmdBreakStart,
  input  logic                cmdBreakStop,
  input  logic                cmdRtsAssert,
  input  logic                wrValid,
  input  logic [DATA_MAX-1:0] wrData,
  input  logic                ctsIn,
  output logic                txd,
  output logic                rtsOut,
  output logic                txRdy,
  output logic                txEmp
);
  tx_strobe_t strobe;
  logic       holdValid, lastBit;

  uart_tx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .cmdBreakStart(cmdBreakStart), .cmdBreakStop(cmdBreakStop),
    .cmdRtsAssert(cmdRtsAssert), .cfgCtsCheck(cfgCtsCheck),
    .cfgAutoRts(cfgAutoRts), .ctsIn(ctsIn), .holdValid(holdValid),
    .lastBit(lastBit), .strobe(strobe), .rtsOut(rtsOut), .txEmp(txEmp)
  );

  uart_tx_dpath #(.DATA_MAX(DATA_MAX)) u_dpath (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity),
    .cfgTwoStop(cfgTwoStop), .strobe(strobe), .txd(txd), .txRdy(txRdy),
    .holdValid(holdValid), .lastBit(lastBit)
  );
endmodule

// File: rtl/uart_tx_hs_chk.sv
module uart_tx_hs_chk (
  input logic clk,
  input logic rstN,
  input logic tick16,
  input logic wrValid,
  input logic cmdReset,
  input logic cmdBreakStart,
  input logic cmdBreakStop,
  input logic txd,
  input logic rtsOut,
  input logic txRdy,
  input logic txEmp
);
  a_r3_txd_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txd) |-> $past(tick16 || cmdReset || cmdBreakStart || cmdBreakStop));

  a_r4_write_takes_slot: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && txRdy && !cmdReset) |=> !txRdy);

  a_r5_empty_is_mark: assert property (@(posedge clk) disable iff (!rstN)
    txEmp |-> txd);

  a_r7_reset_halts: assert property (@(posedge clk) disable iff (!rstN)
    cmdReset |=> (txd && txRdy && txEmp));

  a_r10_break_low: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBreakStart && !cmdReset) |=> !txd);

  a_r12_rts_drop_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rtsOut) |-> $past(tick16));
endmodule

bind uart_tx_hs uart_tx_hs_chk u_chk (.*);

// File: tb/tb_uart_tx_hs.sv
module tb_uart_tx_hs;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, tick16 = 1'b0;
  logic [1:0] cfgDataBits = 2'd3, cfgParity = 2'd0;
  logic cfgTwoStop = 0, cfgCtsCheck = 0, cfgAutoRts = 0;
  logic cmdEnable = 0, cmdDisable = 0, cmdReset = 0;
  logic cmdBreakStart = 0, cmdBreakStop = 0, cmdRtsAssert = 0;
  logic wrValid = 0, ctsIn = 1;
  logic [7:0] wrData = '0;
  logic txd, rtsOut, txRdy, txEmp;

  uart_tx_hs dut (.*);

  logic [1:0] div = '0;
  always @(posedge clk) begin
    div    <= div + 2'd1;
    tick16 <= (div == 2'd3);
  end

  int checks = 0, errors = 0;
  bit finished = 0, monOn = 0, prevTxd = 1;
  logic [7:0] expQ[$];

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  task automatic waitBits(input int n);
    waitTicks(16 * n);
  endtask

  task automatic cmd(input int which);
    @(negedge clk);
    case (which)
      0: cmdEnable = 1;      1: cmdDisable = 1;    2: cmdReset = 1;
      3: cmdBreakStart = 1;  4: cmdBreakStop = 1;  default: cmdRtsAssert = 1;
    endcase
    @(negedge clk);
    {cmdEnable, cmdDisable, cmdReset, cmdBreakStart, cmdBreakStop, cmdRtsAssert} = '0;
  endtask

  // driver: pushes the expected character when it is meant to go out
  task automatic sendChar(input logic [7:0] d, input bit expectIt);
    @(negedge clk);
    while (!txRdy) @(negedge clk);
    wrValid = 1; wrData = d;
    if (expectIt) expQ.push_back(d);
    @(negedge clk);
    wrValid = 0;
  endtask

  task automatic forceWrite(input logic [7:0] d);
    @(negedge clk);
    wrValid = 1; wrData = d;
    @(negedge clk);
    wrValid = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!txEmp) @(negedge clk);
    waitTicks(4);
  endtask

  task automatic waitFall();
    @(negedge clk);
    while (txd) @(negedge clk);
  endtask

  task automatic countLevel(input int bits, input logic lvl, output int hits);
    hits = 0;
    for (int k = 0; k < bits * 64; k++) begin
      @(negedge clk);
      if (txd == lvl) hits++;
    end
  endtask

  // monitor: decodes frames and compares with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && rstN && !txd && prevTxd) begin
        int nb, stopsBad;
        logic [7:0] got, exp, mask;
        logic startOk, pbit, pexp;
        nb = 5 + int'(cfgDataBits);
        got = '0; stopsBad = 0; pbit = 0;
        waitTicks(8);
        startOk = !txd;
        for (int i = 0; i < nb; i++) begin
          waitTicks(16);
          got[i] = txd;
        end
        if (cfgParity == 2'd1 || cfgParity == 2'd2) begin
          waitTicks(16);
          pbit = txd;
        end
        for (int s = 0; s < (cfgTwoStop ? 2 : 1); s++) begin
          waitTicks(16);
          if (!txd) stopsBad++;
        end
        mask = 8'hFF >> (8 - nb);
        if (expQ.size() == 0) begin
          checkEq("R1 unexpected frame", int'(got), -1);
        end else begin
          exp = expQ.pop_front() & mask;
          checkEq("R1 start bit", int'(startOk), 1);
          checkEq("R1 data bits", int'(got), int'(exp));
          checkEq("R1 stop bits low", stopsBad, 0);
          if (cfgParity == 2'd1 || cfgParity == 2'd2) begin
            pexp = ^exp;
            if (cfgParity == 2'd2) pexp = ~pexp;
            checkEq("R2 parity bit", int'(pbit), int'(pexp));
          end
        end
      end
      prevTxd = txd;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkEq("R5 reset txd", int'(txd), 1);
    checkEq("R4 reset txRdy", int'(txRdy), 1);
    checkEq("R5 reset txEmp", int'(txEmp), 1);
    checkEq("R12 reset rtsOut", int'(rtsOut), 0);

    monOn = 1;
    cmd(0);
    sendChar(8'hA5, 1);
    checkEq("R5 txEmp falls on write", int'(txEmp), 0);
    waitIdle();
    checkEq("R5 idle mark", int'(txd), 1);

    // R1 R2 frame variants
    cfgDataBits = 2'd0; cfgParity = 2'd1; cfgTwoStop = 1;
    sendChar(8'h13, 1); waitIdle();
    cfgDataBits = 2'd2; cfgParity = 2'd2; cfgTwoStop = 0;
    sendChar(8'h6B, 1); waitIdle();
    cfgDataBits = 2'd1; cfgParity = 2'd0; cfgTwoStop = 1;
    sendChar(8'h2D, 1); waitIdle();
    cfgDataBits = 2'd3; cfgParity = 2'd1; cfgTwoStop = 0;
    sendChar(8'hC3, 1); waitIdle();
    cfgParity = 2'd2;
    sendChar(8'h00, 1); waitIdle();
    cfgParity = 2'd3;
    sendChar(8'h9C, 1); waitIdle();
    cfgParity = 2'd0;

    // R3 bit length: start + d0 low = 2 bits = 128 clocks
    sendChar(8'hFE, 1);
    waitFall();
    n = 1;
    @(negedge clk);
    while (!txd) begin n++; @(negedge clk); end
    checkRange("R3 two-bit low span", n, 127, 129);
    waitIdle();

    // R4 holding slot, back to back, discarded write
    sendChar(8'h3A, 1);
    checkEq("R4 txRdy low after write", int'(txRdy), 0);
    sendChar(8'hC5, 1);
    forceWrite(8'hEE);
    checkEq("R5 txEmp low while busy", int'(txEmp), 0);
    waitIdle();
    checkEq("R4 queue drained", expQ.size(), 0);

    // R6 disable mid frame, R13 write kept while disabled
    sendChar(8'h3C, 1);
    waitFall(); waitBits(3);
    cmd(1);
    waitIdle();
    checkEq("R6 frame completed", expQ.size(), 0);
    sendChar(8'h55, 1);
    countLevel(20, 1'b0, n);
    checkEq("R13 no start while disabled", n, 0);
    checkEq("R13 txRdy held", int'(txRdy), 0);
    cmd(0);
    waitIdle();
    checkEq("R13 kept char sent", expQ.size(), 0);

    // R7 reset mid frame, R8 enable required
    monOn = 0;
    sendChar(8'h00, 0);
    waitFall(); waitBits(2);
    cmd(2);
    checkEq("R7 txd mark after reset", int'(txd), 1);
    checkEq("R7 slot emptied", int'(txRdy), 1);
    countLevel(12, 1'b0, n);
    checkEq("R7 line stays mark", n, 0);
    monOn = 1;
    sendChar(8'h77, 1);
    countLevel(10, 1'b0, n);
    checkEq("R8 nothing before enable", n, 0);
    cmd(0);
    waitIdle();
    checkEq("R8 sent after enable", expQ.size(), 0);

    // R9 clear-to-send gating
    cfgCtsCheck = 1; ctsIn = 0;
    sendChar(8'h81, 1);
    countLevel(10, 1'b0, n);
    checkEq("R9 held while cts low", n, 0);
    ctsIn = 1;
    waitFall(); waitBits(2);
    ctsIn = 0;
    waitIdle();
    checkEq("R9 frame finished after cts drop", expQ.size(), 0);
    sendChar(8'h4E, 1);
    countLevel(10, 1'b0, n);
    checkEq("R9 mark until cts returns", n, 0);
    ctsIn = 1;
    waitIdle();
    checkEq("R9 sent after cts returns", expQ.size(), 0);

    // R10 break ignores cts, R11 recovery mark
    monOn = 0; ctsIn = 0;
    cmd(3);
    checkEq("R10 break low", int'(txd), 0);
    sendChar(8'h99, 0);
    countLevel(10, 1'b1, n);
    checkEq("R10 break held low", n, 0);
    ctsIn = 1; cfgCtsCheck = 0;
    cmd(4);
    checkEq("R11 mark after break stop", int'(txd), 1);
    monOn = 1;
    expQ.push_back(8'h99);
    n = 0;
    while (txd) begin n++; @(negedge clk); end
    checkRange("R11 mark time before start", n, 64, 80);
    waitIdle();
    checkEq("R11 held char sent", expQ.size(), 0);

    // R12 automatic request-to-send drop
    cfgAutoRts = 1;
    cmd(5);
    checkEq("R12 rts asserted by command", int'(rtsOut), 1);
    sendChar(8'h5A, 1);
    waitFall(); waitBits(2);
    cmd(1);
    @(negedge clk);
    while (!txEmp) @(negedge clk);
    checkEq("R12 rts high at frame end", int'(rtsOut), 1);
    n = 0;
    while (rtsOut) begin n++; @(negedge clk); end
    checkRange("R12 rts drop delay", n, 56, 72);
    checkEq("R12 last frame sent", expQ.size(), 0);
    waitBits(3);
    checkEq("R12 rts stays low", int'(rtsOut), 0);
    cmd(5);
    checkEq("R12 rts reasserted", int'(rtsOut), 1);

    waitBits(2);
    checkEq("R1 no stray frames", expQ.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule